// File: doc/BRIEF.md
# Two-Channel Disk Interface Register Decoder

This block sits between a byte-wide host bus and two parallel disk channels on an expansion card. Each host access is a one-cycle request pulse carrying an address, a direction, write data and a window flag. The block accepts the request, decodes it and asserts the matching chip select toward one channel for exactly one strobe cycle. It then acknowledges with read data. Two kinds of register sit on each channel: eight taskfile registers spaced 64 bytes apart, and one control register. A write to the control register sets the device control value. A read at the same address returns the alternate status from the drive.

Two registers sit inside the block itself.

- **Identity code.** A 4-bit card identity is taken from a strap input. Each bit is read at its own byte address.
- **Select register.** Its bit 5 opens the secondary address window, and its bit 0 chooses which channel the shared DMA path serves.

Software opens the secondary window before taskfile traffic and writes 0 to the select register at shutdown to close it again.

The access sequencer is a three-state machine.

- **States:** `ST_IDLE` waits for a request, `ST_STROBE` drives the drive-side strobe, and `ST_DONE` presents the acknowledge.
- **Transitions:** `ST_IDLE` moves to `ST_STROBE` on an accepted request (*accept*). `ST_STROBE` always moves to `ST_DONE` (*capture*). `ST_DONE` always moves back to `ST_IDLE` (*retire*).

Top module: `duo_ide_decode`

## Requirements
- R1: During and after reset, no chip select or strobe is active, `host_ack` is 0, `dma_chan` is 0, and the secondary window is closed.
- R2: Through the primary window, a read at 0x2280 + 4·k (k = 0..3) returns identity strap bit k in data bit 0, with bits 7:1 zero. The same addresses match nothing through the secondary window.
- R3: An address 0x2000 + (n << 6), n = 0..7, selects channel 1 taskfile register n. It asserts `drv_tf_cs[0]` with `drv_idx` = n. An address in that range with any of bits 5:0 set matches nothing.
- R4: An address 0x3000 + (n << 6) selects channel 2 taskfile register n. It asserts `drv_tf_cs[1]` with `drv_idx` = n.
- R5: Address 0x2380 asserts `drv_ctl_cs[0]` and address 0x3380 asserts `drv_ctl_cs[1]`, both with `drv_idx` = 0. A write drives `drv_wdata` with the host data. A read returns `drv_rdata`, which carries the alternate status.
- R6: A primary-window write to address 0x0000 loads the select register: data bit 5 opens the secondary window, and data bit 0 sets `dma_chan` (0 = channel 1, 1 = channel 2). A write to the same address through the secondary window has no effect.
- R7: While select bit 5 is 0, secondary-window accesses give no chip select and no strobe, and reads return 0xFF. While bit 5 is 1, taskfile and control addresses decode as in the primary window. Writing 0 to the select register closes the window again.
- R8: An address that matches nothing produces no chip select and no strobe, and a read of it returns 0xFF.
- R9: A request taken in `ST_IDLE` gives the strobe in the next cycle and a one-cycle `host_ack` in the cycle after that. A request made while busy is ignored. A write is acknowledged with read data 0xFF. Drive-side strobes are active only in `ST_STROBE`, and each strobe is exactly one of `drv_rd` or `drv_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ident_strap | input | 4 | Card identity code |
| host_req | input | 1 | Access request pulse |
| host_sec | input | 1 | 1 = access through the secondary window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Byte offset of the access |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | Access complete, read data valid |
| host_rdata | output | 8 | Read data |
| drv_tf_cs | output | 2 | Taskfile chip select per channel |
| drv_ctl_cs | output | 2 | Control chip select per channel |
| drv_idx | output | 3 | Taskfile register index |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_wdata | output | 8 | Data toward the drive |
| drv_rdata | input | 8 | Data from the drive |
| dma_chan | output | 1 | Channel served by the shared DMA path |

## Verification
The hardest case to reach is an access through the secondary window while it is open. This case only exists after a primary-window write of the select register, and it must not survive a later write of 0. The stimulus therefore walks the window through closed, open with each DMA target, an ignored secondary-window select write, and closed again. It probes taskfile addresses through the window at each step. A request held high into the strobe cycle checks that the busy sequencer drops it. A strap change between identity sweeps shows that each scattered address returns its own bit.

// File: rtl/duo_ide_pkg.sv
package duo_ide_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_TASK  = 3'd1,
        TGT_CTRL  = 3'd2,
        TGT_IDENT = 3'd3,
        TGT_SELR  = 3'd4
    } tgt_kind_t;

    localparam int unsigned REG_IDX_W = 3;
endpackage

// File: rtl/duo_ide_addrmap.sv
module duo_ide_addrmap
    import duo_ide_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned CH_W      = 1,
    parameter int unsigned CH_BASE   = 32'h2000,
    parameter int unsigned CH_SPAN   = 32'h1000,
    parameter int unsigned CTL_OFS   = 32'h0380,
    parameter int unsigned REG_SHIFT = 6,
    parameter int unsigned NUM_ID    = 4,
    parameter int unsigned ID_BASE   = 32'h2280,
    parameter int unsigned ID_STEP   = 4,
    parameter int unsigned SEL_ADDR  = 0
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 sec_win,
    input  logic                 sec_open,
    output tgt_kind_t            tgt,
    output logic [CH_W-1:0]      chan,
    output logic [REG_IDX_W-1:0] idx
);
    localparam int unsigned TAG_LO = REG_SHIFT + REG_IDX_W;

    logic [NUM_CH-1:0] tf_hit;
    logic [NUM_CH-1:0] ctl_hit;
    logic [NUM_ID-1:0] id_hit;
    logic              sel_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam logic [ADDR_W-1:0] BASE_C = ADDR_W'(CH_BASE + c * CH_SPAN);
        assign tf_hit[c]  = (addr[ADDR_W-1:TAG_LO] == BASE_C[ADDR_W-1:TAG_LO])
                          && (addr[REG_SHIFT-1:0] == '0);
        assign ctl_hit[c] = (addr == ADDR_W'(BASE_C + CTL_OFS));
    end

    for (genvar k = 0; k < NUM_ID; k++) begin : g_ident
        assign id_hit[k] = (addr == ADDR_W'(ID_BASE + k * ID_STEP));
    end

    assign sel_hit = (addr == ADDR_W'(SEL_ADDR));

    always_comb begin
        tgt  = TGT_NONE;
        chan = '0;
        idx  = '0;
        if (!sec_win || sec_open) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (tf_hit[c]) begin
                    tgt  = TGT_TASK;
                    chan = CH_W'(c);
                    idx  = addr[REG_SHIFT +: REG_IDX_W];
                end
                if (ctl_hit[c]) begin
                    tgt  = TGT_CTRL;
                    chan = CH_W'(c);
                end
            end
        end
        if (!sec_win) begin
            for (int k = 0; k < NUM_ID; k++) begin
                if (id_hit[k]) begin
                    tgt = TGT_IDENT;
                    idx = REG_IDX_W'(k);
                end
            end
            if (sel_hit) begin
                tgt = TGT_SELR;
            end
        end
    end
endmodule

// File: rtl/duo_ide_seq.sv
module duo_ide_seq
    import duo_ide_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    output seq_state_t state,
    output logic       accept,
    output logic       in_strobe,
    output logic       ack
);
    seq_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req) state_nx = ST_STROBE;
            ST_STROBE: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        in_strobe = 1'b0;
        ack       = 1'b0;
        unique case (state)
            ST_IDLE:   accept    = req;
            ST_STROBE: in_strobe = 1'b1;
            ST_DONE:   ack       = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/duo_ide_selreg.sv
module duo_ide_selreg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic open_bit,
    input  logic chan_bit,
    output logic sec_open,
    output logic dma_tgt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_open <= 1'b0;
            dma_tgt  <= 1'b0;
        end else if (wr_en) begin
            sec_open <= open_bit;
            dma_tgt  <= chan_bit;
        end
    end
endmodule

// File: rtl/duo_ide_decode.sv
module duo_ide_decode
    import duo_ide_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned NUM_ID     = 4,
    parameter int unsigned CH_BASE    = 32'h2000,
    parameter int unsigned CH_SPAN    = 32'h1000,
    parameter int unsigned CTL_OFS    = 32'h0380,
    parameter int unsigned REG_SHIFT  = 6,
    parameter int unsigned ID_BASE    = 32'h2280,
    parameter int unsigned ID_STEP    = 4,
    parameter int unsigned SEL_ADDR   = 0,
    parameter int unsigned SEC_EN_BIT = 5,
    parameter int unsigned DMA_BIT    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_ID-1:0]    ident_strap,
    input  logic                 host_req,
    input  logic                 host_sec,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_ack,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [NUM_CH-1:0]    drv_tf_cs,
    output logic [NUM_CH-1:0]    drv_ctl_cs,
    output logic [REG_IDX_W-1:0] drv_idx,
    output logic                 drv_rd,
    output logic                 drv_wr,
    output logic [DATA_W-1:0]    drv_wdata,
    input  logic [DATA_W-1:0]    drv_rdata,
    output logic                 dma_chan
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned ID_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1;

    seq_state_t             state;
    logic                   accept;
    logic                   in_strobe;
    logic                   sec_open;
    logic [ADDR_W-1:0]      lat_addr;
    logic [DATA_W-1:0]      lat_wdata;
    logic                   lat_we;
    logic                   lat_sec;
    tgt_kind_t              tgt;
    logic [CH_W-1:0]        chan;
    logic [REG_IDX_W-1:0]   idx;
    logic                   drv_go;
    logic                   sel_wr;
    logic [DATA_W-1:0]      rd_mux;

    duo_ide_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .state     (state),
        .accept    (accept),
        .in_strobe (in_strobe),
        .ack       (host_ack)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_we    <= 1'b0;
            lat_sec   <= 1'b0;
        end else if (accept) begin
            lat_addr  <= host_addr;
            lat_wdata <= host_wdata;
            lat_we    <= host_we;
            lat_sec   <= host_sec;
        end
    end

    duo_ide_addrmap #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .CH_W      (CH_W),
        .CH_BASE   (CH_BASE),
        .CH_SPAN   (CH_SPAN),
        .CTL_OFS   (CTL_OFS),
        .REG_SHIFT (REG_SHIFT),
        .NUM_ID    (NUM_ID),
        .ID_BASE   (ID_BASE),
        .ID_STEP   (ID_STEP),
        .SEL_ADDR  (SEL_ADDR)
    ) u_map (
        .addr     (lat_addr),
        .sec_win  (lat_sec),
        .sec_open (sec_open),
        .tgt      (tgt),
        .chan     (chan),
        .idx      (idx)
    );

    assign sel_wr = in_strobe && lat_we && (tgt == TGT_SELR);

    duo_ide_selreg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr),
        .open_bit (lat_wdata[SEC_EN_BIT]),
        .chan_bit (lat_wdata[DMA_BIT]),
        .sec_open (sec_open),
        .dma_tgt  (dma_chan)
    );

    assign drv_go = (tgt == TGT_TASK) || (tgt == TGT_CTRL);

    always_comb begin
        drv_tf_cs  = '0;
        drv_ctl_cs = '0;
        drv_idx    = '0;
        drv_rd     = 1'b0;
        drv_wr     = 1'b0;
        drv_wdata  = '0;
        if (in_strobe && drv_go) begin
            if (tgt == TGT_TASK) begin
                drv_tf_cs[chan] = 1'b1;
                drv_idx         = idx;
            end else begin
                drv_ctl_cs[chan] = 1'b1;
            end
            drv_rd = !lat_we;
            drv_wr = lat_we;
            if (lat_we) drv_wdata = lat_wdata;
        end
    end

    always_comb begin
        rd_mux = '1;
        if (!lat_we) begin
            case (tgt)
                TGT_TASK, TGT_CTRL: rd_mux = drv_rdata;
                TGT_IDENT:          rd_mux = DATA_W'(ident_strap[idx[ID_W-1:0]]);
                default:            rd_mux = '1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (in_strobe) begin
            host_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/duo_ide_decode_chk.sv
module duo_ide_decode_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tf_cs,
    input logic [NUM_CH-1:0] ctl_cs,
    input logic              rd,
    input logic              wr,
    input logic              ack,
    input logic              dma_tgt,
    input logic              sec_win,
    input logic              sec_open
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tf_cs, ctl_cs})); // R3

    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || wr) |-> (|{tf_cs, ctl_cs})); // R5

    AST_CS_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{tf_cs, ctl_cs}) |-> (rd ^ wr)); // R9

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R9

    AST_DMA_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dma_tgt) |-> ack); // R6

    AST_SEC_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_win && !sec_open) |-> (!(|{tf_cs, ctl_cs}) && !rd && !wr)); // R7
endmodule

bind duo_ide_decode duo_ide_decode_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tf_cs    (drv_tf_cs),
    .ctl_cs   (drv_ctl_cs),
    .rd       (drv_rd),
    .wr       (drv_wr),
    .ack      (host_ack),
    .dma_tgt  (dma_chan),
    .sec_win  (lat_sec),
    .sec_open (sec_open)
);

// File: tb/test_duo_ide_decode.sv
module test_duo_ide_decode;
    localparam int K_NONE = 0, K_TASK = 1, K_CTRL = 2, K_IDENT = 3, K_SELR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ident_strap = 4'b0011;
    logic        host_req = 1'b0;
    logic        host_sec = 1'b0;
    logic        host_we = 1'b0;
    logic [13:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic [1:0]  drv_tf_cs;
    logic [1:0]  drv_ctl_cs;
    logic [2:0]  drv_idx;
    logic        drv_rd;
    logic        drv_wr;
    logic [7:0]  drv_wdata;
    logic [7:0]  drv_rdata = 8'h00;
    logic        dma_chan;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    // reference model state
    int m_phase = 0;
    bit m_sec, m_we, m_open, m_dma;
    int m_addr, m_wdata, m_rd;

    always #2 clk = ~clk;

    duo_ide_decode i_duo_ide_decode (
        .clk(clk), .rst_n(rst_n), .ident_strap(ident_strap),
        .host_req(host_req), .host_sec(host_sec), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .drv_tf_cs(drv_tf_cs), .drv_ctl_cs(drv_ctl_cs), .drv_idx(drv_idx),
        .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .dma_chan(dma_chan)
    );

    function automatic int ref_kind(input bit sec, input bit open, input int a,
                                     output int ch, output int n);
        ch = 0;
        n  = 0;
        if (sec && !open) return K_NONE;
        for (int c = 0; c < 2; c++) begin
            int base = 'h2000 + c * 'h1000;
            if (a >= base && a < base + 512 && (a % 64) == 0) begin
                ch = c;
                n  = (a - base) / 64;
                return K_TASK;
            end
            if (a == base + 'h380) begin
                ch = c;
                return K_CTRL;
            end
        end
        if (!sec) begin
            for (int k = 0; k < 4; k++) begin
                if (a == 'h2280 + 4 * k) begin
                    n = k;
                    return K_IDENT;
                end
            end
            if (a == 0) return K_SELR;
        end
        return K_NONE;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_open  = 0;
            m_dma   = 0;
        end else begin
            case (m_phase)
                0: if (host_req) begin
                    m_sec = host_sec; m_we = host_we;
                    m_addr = host_addr; m_wdata = host_wdata;
                    m_phase = 1;
                end
                1: begin
                    int ch, n, k;
                    k = ref_kind(m_sec, m_open, m_addr, ch, n);
                    if (m_we) begin
                        m_rd = 255;
                        if (k == K_SELR) begin
                            m_open = m_wdata[5];
                            m_dma  = m_wdata[0];
                        end
                    end else if (k == K_TASK || k == K_CTRL) m_rd = drv_rdata;
                    else if (k == K_IDENT) m_rd = ident_strap[n];
                    else m_rd = 255;
                    m_phase = 2;
                end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        int ch, n, k;
        int e_tf, e_ctl, e_idx, e_rd, e_wr;
        k = ref_kind(m_sec, m_open, m_addr, ch, n);
        e_tf = 0; e_ctl = 0; e_idx = 0; e_rd = 0; e_wr = 0;
        if (m_phase == 1) begin
            if (k == K_TASK) begin e_tf = 1 << ch; e_idx = n; end
            if (k == K_CTRL) e_ctl = 1 << ch;
            if (k == K_TASK || k == K_CTRL) begin e_rd = !m_we; e_wr = m_we; end
        end
        chk("tf_cs", drv_tf_cs, e_tf);
        chk("ctl_cs", drv_ctl_cs, e_ctl);
        chk("idx", drv_idx, e_idx);
        chk("rd", drv_rd, e_rd);
        chk("wr", drv_wr, e_wr);
        chk("wdata", drv_wdata, e_wr ? m_wdata : 0);
        chk("ack", host_ack, m_phase == 2);
        if (m_phase == 2) chk("rdata", host_rdata, m_rd);
        chk("dma_chan", dma_chan, m_dma);
    end

    task automatic access(input string tag, input bit sec, input bit we,
                          input int addr, input int wdata, input int dd);
        @(posedge clk); #1;
        cur_tag = tag;
        host_sec = sec; host_we = we; host_addr = addr[13:0];
        host_wdata = wdata[7:0]; drv_rdata = dd[7:0]; host_req = 1'b1;
        @(posedge clk); #1;
        host_req = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2: identity bits at scattered addresses, two strap values
        for (int k = 0; k < 4; k++) access("R2", 0, 0, 'h2280 + 4 * k, 0, 'h5A);
        ident_strap = 4'b1010;
        for (int k = 0; k < 4; k++) access("R2", 0, 0, 'h2280 + 4 * k, 0, 'h5A);

        // R3: channel 1 taskfile
        for (int n = 0; n < 8; n++) access("R3", 0, 0, 'h2000 + (n << 6), 0, 'h10 + n);
        access("R3", 0, 1, 'h21C0, 'hA7, 0);
        access("R3", 0, 0, 'h2001, 0, 'h33);
        access("R3", 0, 0, 'h2060, 0, 'h33);

        // R4: channel 2 taskfile
        for (int n = 0; n < 8; n++) access("R4", 0, 0, 'h3000 + (n << 6), 0, 'hC0 + n);
        access("R4", 0, 1, 'h3080, 'h3C, 0);

        // R5: control / alternate status
        access("R5", 0, 1, 'h2380, 'h06, 0);
        access("R5", 0, 0, 'h2380, 0, 'h50);
        access("R5", 0, 1, 'h3380, 'h02, 0);
        access("R5", 0, 0, 'h3380, 0, 'hD1);

        // R7: closed secondary window
        access("R7", 1, 0, 'h2000, 0, 'h44);
        access("R7", 1, 1, 'h3040, 'h99, 0);
        access("R2", 1, 0, 'h2284, 0, 'h44);

        // R6: select register
        access("R6", 0, 1, 0, 'h21, 0);
        access("R7", 1, 0, 'h3080, 0, 'h77);
        access("R7", 1, 1, 'h2380, 'h0E, 0);
        access("R2", 1, 0, 'h2280, 0, 'h77);
        access("R6", 1, 1, 0, 'h20, 0);
        access("R6", 0, 1, 0, 'h20, 0);
        access("R7", 1, 0, 'h2040, 0, 'h88);
        access("R7", 0, 1, 0, 'h00, 0);
        access("R7", 1, 0, 'h2040, 0, 'h88);
        access("R6", 0, 0, 0, 0, 'h12);

        // R8: unmatched addresses
        access("R8", 0, 0, 'h1234, 0, 'h00);
        access("R8", 0, 1, 'h2200, 'h55, 0);
        access("R8", 0, 0, 'h3FFF, 0, 'h00);

        // R9: request held into the strobe cycle is dropped
        @(posedge clk); #1;
        cur_tag = "R9";
        host_sec = 0; host_we = 0; host_addr = 14'h2040; drv_rdata = 8'h61; host_req = 1'b1;
        @(posedge clk); #1;
        host_addr = 14'h3040;
        @(posedge clk); #1;
        host_req = 1'b0;
        repeat (3) @(posedge clk);
        access("R9", 0, 1, 'h2100, 'hFE, 0);

        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule